// File: doc/BRIEF.md
# Sequenced AND-OR Logic Array

This block evaluates a programmable two-level logic function. Each product term ANDs a chosen set of true or inverted inputs, and each output ORs a chosen set of product terms. An output such as F = a·b + c·d therefore takes two product terms and one output mask. The two planes are held in configuration registers, which are written one row at a time through a simple write port.

A start pulse runs one evaluation through four fixed phases. The inputs are captured first and the product lines are precharged. The sum lines are precharged next. The products are then evaluated, and last the sums are evaluated and the results are latched onto the outputs. The precharge levels of the internal lines can be seen on debug ports, so each phase can be observed.

When feedback is selected at start, the two lowest input positions take the previously latched outputs. The array then steps as a state machine, one state per evaluation.

Top module: `pla4_engine`

## Requirements
- R1: After reset, out_data, dbg_prod, dbg_sum, busy and done are all zero, and every configuration row is zero.
- R2: A start seen while busy is low makes busy high for exactly four cycles (T1 to T4). done is high only in T4, and busy and done are both low in the cycle after T4.
- R3: In T1 and T2, dbg_prod reads all ones.
- R4: In T2 and T3, dbg_sum reads all zeros.
- R5: In T3, dbg_prod holds the product terms of the inputs captured on the start edge. Later changes to in_data or fb_en do not affect them.
- R6: In T4, out_data and dbg_sum both show the OR-plane result. out_data changes only at the edge that enters T4.
- R7: Product term t uses bits [2i+1:2i] of its AND row for input i. Code 00 ignores the input, 01 needs the input to be 1, 10 needs it to be 0, and 11 forces the term to 0. A row of all 00 gives a term that is always 1.
- R8: Output j is the OR of every product term t whose bit t is set in OR row j. An OR row of zero gives 0.
- R9: A configuration write is taken only while busy is low. cfg_plane=0 selects AND row cfg_addr, and cfg_plane=1 selects OR row cfg_addr. Writes made while busy are dropped.
- R10: A start seen while busy, including in T4, is ignored and does not launch a new evaluation.
- R11: If fb_en is high on the start edge, input positions 1:0 are replaced by the out_data[1:0] held at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_plane | input | 1 | 0 selects the AND plane, 1 selects the OR plane |
| cfg_addr | input | 4 | Row index (product term or output) |
| cfg_data | input | 16 | Row contents |
| start | input | 1 | Begins one four-phase evaluation |
| fb_en | input | 1 | Selects output feedback for this evaluation |
| in_data | input | 8 | Array inputs |
| busy | output | 1 | Evaluation in progress |
| done | output | 1 | High in phase T4 |
| out_data | output | 4 | Latched outputs |
| dbg_prod | output | 16 | Product lines |
| dbg_sum | output | 4 | Sum lines |

## Verification
The bench changes in_data and fb_en right after the start edge. A design that sampled its inputs late would therefore produce different products in T3. It checks the precharge levels in each phase, so swapping the phases or skipping a precharge shows up on the debug ports. It drives a configuration write and extra start pulses while busy. This exposes a design that lets the write corrupt the OR row or that restarts from T4. Last, a chain of feedback evaluations with known results catches feedback taken from the wrong bits or at the wrong time.

// File: rtl/pla4_engine.sv
module pla4_engine #(
  parameter int N_IN   = 8,
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4,
  parameter int N_FB   = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic                 cfg_plane,
  input  logic [$clog2(N_TERM)-1:0] cfg_addr,
  input  logic [((2*N_IN > N_TERM) ? 2*N_IN : N_TERM)-1:0] cfg_data,
  input  logic                 start,
  input  logic                 fb_en,
  input  logic [N_IN-1:0]      in_data,
  output logic                 busy,
  output logic                 done,
  output logic [N_OUT-1:0]     out_data,
  output logic [N_TERM-1:0]    dbg_prod,
  output logic [N_OUT-1:0]     dbg_sum
);
  localparam int AW = $clog2(N_TERM);

  typedef enum logic [2:0] {S_IDLE, S_T1, S_T2, S_T3, S_T4} phase_t;

  phase_t              state;
  logic [2*N_IN-1:0]   and_pl [N_TERM];
  logic [N_TERM-1:0]   or_pl  [N_OUT];
  logic [N_IN-1:0]     in_lat, in_mix;
  logic [N_TERM-1:0]   prod_q, prod_eval;
  logic [N_OUT-1:0]    sum_q, sum_eval, out_q;

  wire idle = (state == S_IDLE);

  assign busy     = !idle;
  assign done     = (state == S_T4);
  assign out_data = out_q;
  assign dbg_prod = prod_q;
  assign dbg_sum  = sum_q;

  generate
    if (N_FB > 0) begin : g_fb
      assign in_mix = fb_en ? {in_data[N_IN-1:N_FB], out_q[N_FB-1:0]} : in_data;
    end else begin : g_nofb
      assign in_mix = in_data;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < N_TERM; t++) and_pl[t] <= '0;
      for (int j = 0; j < N_OUT; j++)  or_pl[j]  <= '0;
    end else if (cfg_we && idle) begin
      for (int t = 0; t < N_TERM; t++)
        if (!cfg_plane && cfg_addr == AW'(t)) and_pl[t] <= cfg_data[2*N_IN-1:0];
      for (int j = 0; j < N_OUT; j++)
        if (cfg_plane && cfg_addr == AW'(j)) or_pl[j] <= cfg_data[N_TERM-1:0];
    end
  end

  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      prod_eval[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (and_pl[t][2*i]   && !in_lat[i]) prod_eval[t] = 1'b0;
        if (and_pl[t][2*i+1] &&  in_lat[i]) prod_eval[t] = 1'b0;
      end
    end
    for (int j = 0; j < N_OUT; j++) sum_eval[j] = |(prod_q & or_pl[j]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      in_lat <= '0;
      prod_q <= '0;
      sum_q  <= '0;
      out_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state  <= S_T1;
          in_lat <= in_mix;
          prod_q <= '1;
        end
        S_T1: begin
          state <= S_T2;
          sum_q <= '0;
        end
        S_T2: begin
          state  <= S_T3;
          prod_q <= prod_eval;
        end
        S_T3: begin
          state <= S_T4;
          sum_q <= sum_eval;
          out_q <= sum_eval;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

module pla4_engine_chk #(
  parameter int N_TERM = 16,
  parameter int N_OUT  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [N_OUT-1:0]  out_data,
  input logic [N_TERM-1:0] dbg_prod,
  input logic [N_OUT-1:0]  dbg_sum
);
  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R2
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R3
  prod_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dbg_prod == '1));
  // R4
  sum_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (dbg_sum == '0));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(out_data));
  // R6
  sum_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dbg_sum == out_data));
endmodule

bind pla4_engine pla4_engine_chk #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .out_data(out_data), .dbg_prod(dbg_prod), .dbg_sum(dbg_sum)
);

// File: tb/pla4_engine_tb.sv
module pla4_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0, cfg_plane = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_data = '0;
  logic        start = 1'b0, fb_en = 1'b0;
  logic [7:0]  in_data = '0;
  logic        busy, done;
  logic [3:0]  out_data, dbg_sum;
  logic [15:0] dbg_prod;

  int checks = 0, errors = 0;
  logic [15:0] and_m [16];
  logic [15:0] or_m  [4];
  logic [3:0]  last_exp = '0;
  logic [3:0]  sb_q [$];

  always #4 clk = ~clk;

  pla4_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_plane(cfg_plane),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .start(start), .fb_en(fb_en),
    .in_data(in_data), .busy(busy), .done(done), .out_data(out_data),
    .dbg_prod(dbg_prod), .dbg_sum(dbg_sum)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_prod(input logic [7:0] v);
    logic [15:0] p;
    for (int t = 0; t < 16; t++) begin
      p[t] = 1'b1;
      for (int i = 0; i < 8; i++)
        case (and_m[t][2*i +: 2])
          2'b01: if (!v[i]) p[t] = 1'b0;
          2'b10: if (v[i])  p[t] = 1'b0;
          2'b11: p[t] = 1'b0;
          default: ;
        endcase
    end
    return p;
  endfunction

  function automatic logic [3:0] model_sum(input logic [15:0] p);
    logic [3:0] s;
    for (int j = 0; j < 4; j++) s[j] = |(p & or_m[j]);
    return s;
  endfunction

  task automatic cfg_write(input logic pl, input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_plane = pl; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (!pl) and_m[a] = d; else if (a < 4) or_m[a] = d;
  endtask

  task automatic run_eval(input logic [7:0] x, input logic fb, input logic poke);
    logic [7:0]  mix;
    logic [15:0] pexp;
    logic [3:0]  oexp, prev;
    prev = last_exp;
    mix  = fb ? {x[7:2], last_exp[1:0]} : x;
    pexp = model_prod(mix);
    oexp = model_sum(pexp);
    @(negedge clk);
    in_data = x; fb_en = fb; start = 1'b1;
    @(negedge clk); // T1
    start = 1'b0; in_data = ~x; fb_en = ~fb;
    chk(busy && !done, "R2 T1 busy/done", {busy, done}, 2'b10);
    chk(dbg_prod == 16'hFFFF, "R3 T1 product precharge", dbg_prod, 16'hFFFF);
    chk(out_data == prev, "R6 hold in T1", out_data, prev);
    if (poke) begin
      start = 1'b1; cfg_we = 1'b1; cfg_plane = 1'b1; cfg_addr = 4'd0; cfg_data = 16'h0000;
    end
    sb_q.push_back(oexp);
    last_exp = oexp;
    @(negedge clk); // T2
    cfg_we = 1'b0; start = 1'b0;
    chk(dbg_prod == 16'hFFFF, "R3 T2 product precharge", dbg_prod, 16'hFFFF);
    chk(dbg_sum == 4'h0, "R4 T2 sum precharge", dbg_sum, 0);
    @(negedge clk); // T3
    chk(dbg_prod == pexp, "R5 T3 products", dbg_prod, pexp);
    chk(dbg_sum == 4'h0, "R4 T3 sum precharge", dbg_sum, 0);
    chk(out_data == prev, "R6 hold in T3", out_data, prev);
    @(negedge clk); // T4
    chk(done && busy, "R2 T4 done", {busy, done}, 2'b11);
    if (poke) start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(!busy && !done, "R10 R2 idle after T4", {busy, done}, 2'b00);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk(1'b0, "R6 unexpected result", out_data, 0);
      else begin
        logic [3:0] e;
        e = sb_q.pop_front();
        chk(out_data == e, "R6 scoreboard out_data", out_data, e);
        chk(dbg_sum == e, "R6 scoreboard dbg_sum", dbg_sum, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int t = 0; t < 16; t++) and_m[t] = '0;
    for (int j = 0; j < 4; j++) or_m[j] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(out_data == 0 && dbg_prod == 0 && dbg_sum == 0, "R1 reset outputs",
        {out_data, dbg_prod, dbg_sum}, 0);
    chk(!busy && !done, "R1 reset flags", {busy, done}, 0);
    run_eval(8'h00, 1'b0, 1'b0);
    chk(out_data == 4'b0000, "R1 R8 zero OR rows", out_data, 0);

    cfg_write(1'b0, 4'd0, 16'h0005); // in0 & in1
    cfg_write(1'b0, 4'd1, 16'h0050); // in2 & in3
    cfg_write(1'b0, 4'd2, 16'h0200); // !in4
    cfg_write(1'b0, 4'd3, 16'h0C00); // never
    cfg_write(1'b1, 4'd0, 16'h0003);
    cfg_write(1'b1, 4'd1, 16'h0004);
    cfg_write(1'b1, 4'd2, 16'h0008);
    cfg_write(1'b1, 4'd3, 16'h0000);

    run_eval(8'h03, 1'b0, 1'b0);
    chk(out_data == 4'b0011, "R7 R8 a.b term and inverted term", out_data, 4'b0011);
    run_eval(8'h1C, 1'b0, 1'b0);
    chk(out_data == 4'b0001, "R7 c.d term", out_data, 4'b0001);
    run_eval(8'h0C, 1'b0, 1'b1);
    chk(out_data == 4'b0011, "R10 poke run result", out_data, 4'b0011);
    run_eval(8'h1C, 1'b0, 1'b0);
    chk(out_data == 4'b0001, "R9 busy write dropped", out_data, 4'b0001);
    run_eval(8'h03, 1'b0, 1'b0);
    run_eval(8'h00, 1'b1, 1'b0);
    chk(out_data == 4'b0011, "R11 feedback fills in1:in0", out_data, 4'b0011);
    run_eval(8'h10, 1'b1, 1'b0);
    chk(out_data == 4'b0001, "R11 feedback step 2", out_data, 4'b0001);
    run_eval(8'h10, 1'b1, 1'b0);
    chk(out_data == 4'b0000, "R11 feedback step 3", out_data, 4'b0000);
    run_eval(8'hFF, 1'b0, 1'b0);
    chk(out_data == 4'b0001, "R7 all ones input", out_data, 4'b0001);

    cfg_write(1'b0, 4'd3, 16'h0000);
    run_eval(8'h00, 1'b0, 1'b0);
    chk(out_data == 4'b0110, "R7 all-ignore term is true", out_data, 4'b0110);
    chk(sb_q.size() == 0, "R6 scoreboard drained", sb_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule